// File: doc/BRIEF.md
# Multiplexed Byte-Wide Register Bus Slave

This block lets a host that has only general-purpose I/O pins reach a set of internal registers. Index and data travel over one 8-bit bus. A dedicated select pin says which one is on the bus. When the select pin is high, a write strobe loads an 8-bit register index into the block. When the select pin is low, a read or write strobe reaches the register that the index names. An active-low ready pin tells the host when the access has finished. The host pins are asynchronous to the core clock, so every pin passes through a two-flop synchronizer. The block acts on a falling strobe only while chip select is low.

Toward the rest of the chip the block offers a plain register port. That port has an index, write data, a write pulse, a read pulse and a read-data return. Two cases are handled locally and never reach that port. The first is the revision index 0x0F, which returns a build-time constant. The second is a read with the select pin high, which returns the index currently latched. An interrupt request from the core is registered and driven out on an active-low pin. The bus output driver is modelled as a data output plus an enable. The enable is asserted only while chip select and read are both low.

Top module: `gpio_reg_bus_slave`

## Requirements
- R1: After reset the outputs are in their idle state. Ready is high, the interrupt pin is high, the output enable is low and there are no register pulses. The latched index is 0x00.
- R2: A write strobe with the select pin high (index phase) loads the bus byte into the latched index. It produces no write pulse on the register port.
- R3: A write strobe with the select pin low (data phase) raises `reg_we`. The pulse carries the latched index on `reg_idx` and the bus byte on `reg_wdata`.
- R4: A read strobe in the data phase, for any index other than 0x0F, raises `reg_re`. The value returned on `reg_rdata` is then presented on `bus_dout` while ready is low.
- R5: A data-phase read of index 0x0F returns the REVISION parameter (default 0x3C). It raises no `reg_re`.
- R6: Ready stays high after a strobe falls, until the write is committed or the read data is held. It then stays low until both strobes are high again, and then returns high.
- R7: `bus_oe` is high only while `bus_cs_n` and `bus_rd_n` are both low.
- R8: Strobes with `bus_cs_n` high are ignored. They produce no pulse and no ready, and they leave the latched index unchanged.
- R9: The latched index is kept across data phases, so back-to-back data accesses reach the same register.
- R10: `bus_irq_n` is the inverse of `irq_req`, delayed by one clock.
- R11: `reg_we` and `reg_re` each last exactly one clock per strobe.
- R12: A read strobe with the select pin high returns the latched index on `bus_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_sel | input | 1 | High: index phase, low: data phase |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_din | input | 8 | Byte driven by the host |
| bus_dout | output | 8 | Byte returned to the host |
| bus_oe | output | 1 | Output driver enable for bus_dout |
| bus_rdy_n | output | 1 | Access complete, active low |
| bus_irq_n | output | 1 | Interrupt to host, active low |
| irq_req | input | 1 | Interrupt request from the core |
| reg_idx | output | 8 | Latched register index |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-clock register write pulse |
| reg_re | output | 1 | One-clock register read pulse |
| reg_rdata | input | 8 | Register read data, valid in the reg_re cycle |

## Verification
The hardest situation to reach is a strobe that falls while chip select is high. A normal host access always lowers chip select first, so this case never arises on its own. The bench drives this case directly, with stray write and read strobes. It then checks three things at the pins: that ready never falls, that no pulse reaches the register port, and, through a later index-phase read, that the latched index survived. A second subtle case is that ready must still be high in the cycles just after a strobe falls. The bench samples ready one clock after each strobe edge to see the synchronizer latency before the handshake completes.

// File: rtl/gbs_pkg.sv
package gbs_pkg;
    localparam int BUS_W = 8;

    // Host control pins after synchronization, all at their pin polarity
    typedef struct packed {
        logic cs_n;
        logic sel;
        logic wr_n;
        logic rd_n;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);
endpackage

// File: rtl/gbs_sync.sv
// gbs_sync: multi-stage flop chain per bit that brings asynchronous host pins
// into the core clock. Assumes multi-bit fields (the data byte) are held
// stable by the host around the strobe edge, so per-bit skew is harmless.
module gbs_sync #(
    parameter int          W      = 8,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gbs_strobe_ctrl.sv
// gbs_strobe_ctrl: detects falling read/write strobes while chip select is low
// and runs the ready handshake. Assumes its inputs are already synchronized.
// Write has priority if both strobes fall in the same cycle.
module gbs_strobe_ctrl
    import gbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t pins,
    output logic    wr_evt,
    output logic    rd_evt,
    output logic    rdy_q
);
    logic wr_prev, rd_prev;

    // Remember the previous strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev <= 1'b1;
            rd_prev <= 1'b1;
        end else begin
            wr_prev <= pins.wr_n;
            rd_prev <= pins.rd_n;
        end
    end

    // Falling edges count only while the chip is selected
    always_comb begin
        wr_evt = wr_prev && !pins.wr_n && !pins.cs_n;
        rd_evt = rd_prev && !pins.rd_n && !pins.cs_n && !wr_evt;
    end

    // Ready goes active on commit and drops once both strobes are released
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else if (wr_evt || rd_evt) rdy_q <= 1'b1;
        else if (pins.wr_n && pins.rd_n) rdy_q <= 1'b0;
    end
endmodule

// File: rtl/gbs_read_mux.sv
// gbs_read_mux: chooses the byte returned to the host. Index-phase reads give
// back the latched index, the revision index gives a constant, and all other
// data-phase reads take the core's register data.
module gbs_read_mux #(
    parameter int             W        = 8,
    parameter logic [W-1:0]   REV_IDX  = 8'h0F,
    parameter logic [W-1:0]   REVISION = 8'h3C
) (
    input  logic         idx_phase,
    input  logic [W-1:0] idx,
    input  logic [W-1:0] core_rdata,
    output logic         local_hit,
    output logic [W-1:0] value
);
    // Pick the source of the read byte
    always_comb begin
        local_hit = idx_phase || (idx == REV_IDX);
        if (idx_phase)             value = idx;
        else if (idx == REV_IDX)   value = REVISION;
        else                       value = core_rdata;
    end
endmodule

// File: rtl/gpio_reg_bus_slave.sv
// gpio_reg_bus_slave: register slave behind a byte-wide bus that carries both
// index and data, selected by bus_sel. Host pins are synchronized, strobes act
// on their falling edge while selected, and bus_rdy_n completes the handshake.
// Assumes the host holds bus_din and bus_sel stable while a strobe is low.
module gpio_reg_bus_slave
    import gbs_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [BUS_W-1:0] REV_IDX     = 8'h0F,
    parameter logic [BUS_W-1:0] REVISION    = 8'h3C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs_n,
    input  logic             bus_sel,
    input  logic             bus_wr_n,
    input  logic             bus_rd_n,
    input  logic [BUS_W-1:0] bus_din,
    output logic [BUS_W-1:0] bus_dout,
    output logic             bus_oe,
    output logic             bus_rdy_n,
    output logic             bus_irq_n,
    input  logic             irq_req,
    output logic [BUS_W-1:0] reg_idx,
    output logic [BUS_W-1:0] reg_wdata,
    output logic             reg_we,
    output logic             reg_re,
    input  logic [BUS_W-1:0] reg_rdata
);
    localparam int SYNC_W = STROBE_W + BUS_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1011, {BUS_W{1'b0}}};

    strobe_t          pins_s;
    logic [BUS_W-1:0] din_s;
    logic             wr_evt, rd_evt, rdy_q;
    logic             local_hit;
    logic [BUS_W-1:0] rd_value;
    logic [BUS_W-1:0] idx_q, rdata_q;
    logic             irq_q;

    gbs_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_cs_n, bus_sel, bus_wr_n, bus_rd_n, bus_din}),
        .q     ({pins_s, din_s})
    );

    gbs_strobe_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins   (pins_s),
        .wr_evt (wr_evt),
        .rd_evt (rd_evt),
        .rdy_q  (rdy_q)
    );

    gbs_read_mux #(.W(BUS_W), .REV_IDX(REV_IDX), .REVISION(REVISION)) u_rmux (
        .idx_phase  (pins_s.sel),
        .idx        (idx_q),
        .core_rdata (reg_rdata),
        .local_hit  (local_hit),
        .value      (rd_value)
    );

    // Latch the register index during index-phase writes
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else if (wr_evt && pins_s.sel) idx_q <= din_s;
    end

    // Hold the read byte for the host once a read strobe is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_evt) rdata_q <= rd_value;
    end

    // Register the interrupt request toward the host pin
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else irq_q <= irq_req;
    end

    // Drive the register port and host-side outputs
    always_comb begin
        reg_idx   = idx_q;
        reg_wdata = din_s;
        reg_we    = wr_evt && !pins_s.sel;
        reg_re    = rd_evt && !local_hit;
        bus_dout  = rdata_q;
        bus_oe    = !bus_cs_n && !bus_rd_n;
        bus_rdy_n = !rdy_q;
        bus_irq_n = !irq_q;
    end
endmodule

// File: rtl/gbs_checker.sv
// gbs_checker: temporal properties of gpio_reg_bus_slave, attached by bind.
module gbs_checker #(
    parameter logic [7:0] REV_IDX = 8'h0F
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_cs_n,
    input logic       bus_rd_n,
    input logic       bus_oe,
    input logic       bus_rdy_n,
    input logic       reg_we,
    input logic       reg_re,
    input logic [7:0] reg_idx
);
    // R1: one clock of reset leaves the handshake idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (bus_rdy_n && !reg_we && !reg_re));

    // R11: write pulse lasts a single clock
    assert_we_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R11: read pulse lasts a single clock
    assert_re_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R3 / R6: a committed write turns ready on in the next cycle
    assert_we_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !bus_rdy_n);

    // R4 / R6: a core read turns ready on in the next cycle
    assert_re_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !bus_rdy_n);

    // R5: the revision index never reaches the core
    assert_rev_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> (reg_idx != REV_IDX));

    // R9: a data write leaves the latched index untouched
    assert_idx_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> $stable(reg_idx));

    // R7: driver is off whenever the chip is deselected
    assert_oe_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> !bus_oe);
endmodule

bind gpio_reg_bus_slave gbs_checker #(.REV_IDX(REV_IDX)) u_gbs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_oe    (bus_oe),
    .bus_rdy_n (bus_rdy_n),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_idx   (reg_idx)
);

// File: tb/tb_gpio_reg_bus_slave.sv
module tb_gpio_reg_bus_slave;
    localparam logic [7:0] REV = 8'h3C;
    localparam logic [7:0] XORK = 8'hA5;
    localparam int NV = 12;
    // op: 0 index write, 1 data write, 2 index read, 3 data read; {op, data}
    localparam logic [9:0] VEC [NV] = '{
        {2'd0, 8'h06}, {2'd1, 8'h11}, {2'd1, 8'h22}, {2'd3, 8'h00},
        {2'd0, 8'h0F}, {2'd3, 8'h00}, {2'd0, 8'h0A}, {2'd3, 8'h00},
        {2'd1, 8'hFF}, {2'd2, 8'h00}, {2'd0, 8'h00}, {2'd1, 8'h00}
    };

    logic clk = 0, rst_n = 0;
    logic bus_cs_n = 1, bus_sel = 0, bus_wr_n = 1, bus_rd_n = 1;
    logic [7:0] bus_din = 0, bus_dout, reg_idx, reg_wdata, reg_rdata;
    logic bus_oe, bus_rdy_n, bus_irq_n, irq_req = 0, reg_we, reg_re;
    int checks = 0, errors = 0, cyc = 0;
    int we_cnt = 0, re_cnt = 0;
    logic [7:0] last_idx = 0, last_data = 0;

    always #10 clk = ~clk;

    gpio_reg_bus_slave dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_sel(bus_sel),
        .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_rdy_n(bus_rdy_n),
        .bus_irq_n(bus_irq_n), .irq_req(irq_req), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    // Core register model: read data is a fixed function of the index
    assign reg_rdata = reg_idx ^ XORK;

    // Port monitor for register pulses
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && reg_we) begin
            we_cnt <= we_cnt + 1; last_idx <= reg_idx; last_data <= reg_wdata;
        end
        if (rst_n && reg_re) re_cnt <= re_cnt + 1;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected below limit", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One host access; returns read byte, early ready level and driver state
    task automatic access(input logic [1:0] op, input logic [7:0] data,
                          output logic [7:0] rv, output logic early, output logic oe);
        int n;
        @(negedge clk);
        bus_cs_n = 0; bus_sel = (op == 0 || op == 2); bus_din = data;
        @(negedge clk);
        if (op[1]) bus_rd_n = 0; else bus_wr_n = 0;
        @(negedge clk);
        early = bus_rdy_n;
        n = 0;
        while (bus_rdy_n && n < 50) begin @(negedge clk); n++; end
        if (n >= 50) chk(0, "R6 ready timeout", 1, 0);
        rv = bus_dout; oe = bus_oe;
        bus_rd_n = 1; bus_wr_n = 1;
        n = 0;
        while (!bus_rdy_n && n < 50) begin @(negedge clk); n++; end
        chk(n < 50, "R6 ready release", bus_rdy_n, 1);
        bus_cs_n = 1;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] cur_idx, rv;
        logic early, oe;
        int we0, re0, quiet;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bus_rdy_n === 1 && bus_irq_n === 1 && bus_oe === 0, "R1 idle outputs",
            {bus_rdy_n, bus_irq_n, bus_oe}, 3'b110);
        chk(reg_idx === 8'h00 && reg_we === 0 && reg_re === 0, "R1 index/pulses",
            reg_idx, 0);
        rst_n = 1;
        @(negedge clk);

        cur_idx = 8'h00;
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [7:0] d, exp;
            op = VEC[i][9:8]; d = VEC[i][7:0];
            we0 = we_cnt; re0 = re_cnt;
            access(op, d, rv, early, oe);
            chk(early === 1, "R6 ready high before commit", early, 1);
            case (op)
                2'd0: begin
                    cur_idx = d;
                    chk(we_cnt == we0, "R2 no write pulse in index phase", we_cnt - we0, 0);
                end
                2'd1: begin
                    chk(we_cnt == we0 + 1, "R11 one write pulse", we_cnt - we0, 1);
                    chk(last_idx == cur_idx && last_data == d, "R3/R9 write index+data",
                        {last_idx, last_data}, {cur_idx, d});
                end
                2'd2: chk(rv == cur_idx, "R12 index read", rv, cur_idx);
                default: begin
                    exp = (cur_idx == 8'h0F) ? REV : (cur_idx ^ XORK);
                    chk(rv == exp, (cur_idx == 8'h0F) ? "R5 revision" : "R4 core read", rv, exp);
                    chk(re_cnt == re0 + ((cur_idx == 8'h0F) ? 0 : 1), "R5/R11 read pulse count",
                        re_cnt - re0, (cur_idx == 8'h0F) ? 0 : 1);
                end
            endcase
            if (op[1]) chk(oe === 1, "R7 driver on during read", oe, 1);
        end

        // R7: driver off with chip selected but no read strobe
        @(negedge clk); bus_cs_n = 0; @(negedge clk);
        chk(bus_oe === 0, "R7 driver off without read", bus_oe, 0);
        bus_cs_n = 1;

        // R8: stray strobes with chip deselected
        we0 = we_cnt; re0 = re_cnt; quiet = 1;
        @(negedge clk); bus_sel = 1; bus_din = 8'h77; bus_wr_n = 0;
        repeat (6) begin @(negedge clk); if (!bus_rdy_n) quiet = 0; end
        bus_wr_n = 1; bus_sel = 0; @(negedge clk); bus_rd_n = 0;
        repeat (6) begin
            @(negedge clk);
            if (!bus_rdy_n) quiet = 0;
            if (bus_oe) quiet = 0;
        end
        bus_rd_n = 1;
        chk(quiet == 1, "R8 no ready/driver when deselected", quiet, 1);
        chk(we_cnt == we0 && re_cnt == re0, "R8 no register pulses",
            (we_cnt - we0) + (re_cnt - re0), 0);
        access(2'd2, 8'h00, rv, early, oe);
        chk(rv == cur_idx, "R8 index unchanged", rv, cur_idx);

        // R10: interrupt pin follows request one clock later
        @(negedge clk); irq_req = 1; @(negedge clk);
        chk(bus_irq_n === 0, "R10 irq asserted", bus_irq_n, 0);
        irq_req = 0; @(negedge clk);
        chk(bus_irq_n === 1, "R10 irq released", bus_irq_n, 1);

        // R1: reset mid-run clears the latched index
        rst_n = 0; @(negedge clk); rst_n = 1;
        access(2'd2, 8'h00, rv, early, oe);
        chk(rv == 8'h00, "R1 index cleared by reset", rv, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule